// File: doc/BRIEF.md
# Read-out Event Alignment and Fragment Builder

This block sits between several front-end data streams and a read-out link. For every trigger accept it takes one tag from a tag FIFO. The tag holds the full 24-bit event number and the 12-bit crossing number that the block keeps locally. The block then takes one event piece from each front-end stream, in stream index order. The first beat of each piece is an identifier beat that carries a short event number and a crossing number. The block compares every identifier beat with the local tag. It then emits a single fragment: two header words followed by the payload of all streams, concatenated. The header words carry the event number, the crossing number, a status word and a module identifier.

An identifier mismatch never stops data taking. The fragment is still built and sent with a synchronisation error bit set. That bit stays set on every later fragment until a local front-end reset is applied. While the front-end reset input is high, each tag produces a header-only fragment marked as a front-end error, and the streams are not read. A test mode keeps the stream traffic and the word count, but replaces each payload word with either a fixed pattern or a pattern supplied on an input.

Top module: `evt_frag_builder`

## Requirements
- R1: Every fragment begins with two header words. Word 0 is {MODULE_ID[7:0], event[23:0]} and has the start marker set. Word 1 is {status[15:0], 4'b0, crossing[11:0]}, so status bit i appears at data bit 16+i.
- R2: Payload follows the header. It consists of every beat after the identifier beat of each stream piece, taken from streams in order 0 to N-1. Streams with empty pieces are skipped. The end marker is set on the final payload word only.
- R3: An identifier beat carries the crossing number in data[11:0] and the short event number in data[15:12]. When every stream matches the tag crossing and the low 4 bits of the tag event, status bit0 (sync error) is clear. In live mode, status bit2 (physics data) is set.
- R4: When any stream's short event number or crossing number differs from the tag, the fragment is still sent in full with bit0 set. Bit0 stays set on every later fragment until a front-end reset is applied.
- R5: An event in which every piece is empty is sent as a header-only fragment. The end marker is on word 1 and status bit4 (empty) is set.
- R6: The block emits exactly one fragment per tag, in tag order. A new tag is accepted only after the previous fragment has finished.
- R7: With test_mode_i = 1, each payload word is replaced by FIXED_PATTERN and the word count is unchanged. Status bit3 (test data) is set and bit2 is clear.
- R8: With test_mode_i = 2, each payload word is replaced by test_pattern_i, and bit3 is set.
- R9: A tag accepted while fe_reset_i is high yields a header-only fragment with status bit1 (front-end error) and bit4 set, and bit0 clear. No stream is read for that fragment.
- R10: The start and end markers are never set on the same word, and at most one stream ready is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_valid_i | input | 1 | Trigger tag available |
| tag_ready_o | output | 1 | Tag taken |
| tag_evt_i | input | 24 | Local full event number |
| tag_bcid_i | input | 12 | Local crossing number |
| fe_valid_i | input | N_STREAMS | Stream beat valid, one bit per stream |
| fe_ready_o | output | N_STREAMS | Stream beat taken |
| fe_data_i | input | N_STREAMS*DATA_W | Stream beat data, stream k at bits k*DATA_W |
| fe_last_i | input | N_STREAMS | Final beat of a stream piece |
| fe_reset_i | input | 1 | Local front-end reset in progress |
| test_mode_i | input | 2 | 0 live, 1 fixed pattern, 2 loaded pattern |
| test_pattern_i | input | DATA_W | Loaded test pattern |
| out_valid_o | output | 1 | Fragment word valid |
| out_ready_i | input | 1 | Fragment word taken |
| out_data_o | output | DATA_W | Fragment word |
| out_sop_o | output | 1 | First word of fragment |
| out_eop_o | output | 1 | Last word of fragment |

## Verification
The assertions assume that each stream and the output sink follow valid/ready rules: a stream holds its beat and keeps valid high until the beat is taken. Only under that assumption can the output word stay stable while stalled. They also assume that a non-empty piece has its last flag clear on the identifier beat. The bench honours this by driving each stream from a queue that only advances after an observed handshake. It changes fe_reset_i, test_mode_i and test_pattern_i only while all queues are drained and the block is idle, so every mode is held constant across the events it applies to.

// File: rtl/efb_pkg.sv
package efb_pkg;
  localparam int STATUS_W   = 16;
  localparam int ST_SYNC    = 0;
  localparam int ST_FE_ERR  = 1;
  localparam int ST_PHYS    = 2;
  localparam int ST_TEST    = 3;
  localparam int ST_EMPTY   = 4;

  typedef enum logic [1:0] {
    MODE_LIVE   = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_LOADED = 2'd2
  } pay_mode_e;

  typedef enum logic [1:0] {
    WORD_HDR0 = 2'd0,
    WORD_HDR1 = 2'd1,
    WORD_PAY  = 2'd2
  } word_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_IDS,
    S_HDR0,
    S_HDR1,
    S_PAY
  } fsm_e;
endpackage

// File: rtl/efb_id_check.sv
module efb_id_check #(
  parameter int N_STREAMS = 3,
  parameter int DATA_W    = 32,
  parameter int SHORT_W   = 4,
  parameter int BCID_W    = 12
) (
  input  logic [N_STREAMS*DATA_W-1:0] beat_data_i,
  input  logic [SHORT_W-1:0]          local_evt_i,
  input  logic [BCID_W-1:0]           local_bcid_i,
  output logic [N_STREAMS-1:0]        match_o
);
  for (genvar k = 0; k < N_STREAMS; k++) begin : g_cmp
    logic [DATA_W-1:0]  word;
    logic [BCID_W-1:0]  fe_bcid;
    logic [SHORT_W-1:0] fe_evt;
    assign word     = beat_data_i[k*DATA_W +: DATA_W];
    assign fe_bcid  = word[BCID_W-1:0];
    assign fe_evt   = word[BCID_W +: SHORT_W];
    assign match_o[k] = (fe_bcid == local_bcid_i) && (fe_evt == local_evt_i);
  end
endmodule

// File: rtl/efb_stream_mux.sv
module efb_stream_mux #(
  parameter int N_STREAMS = 3,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic                        en_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [N_STREAMS-1:0]        fe_valid_i,
  input  logic [N_STREAMS*DATA_W-1:0] fe_data_i,
  input  logic [N_STREAMS-1:0]        fe_last_i,
  output logic [N_STREAMS-1:0]        fe_ready_o,
  input  logic                        sel_ready_i,
  output logic                        sel_valid_o,
  output logic [DATA_W-1:0]           sel_data_o,
  output logic                        sel_last_o
);
  logic [N_STREAMS-1:0] hit;

  for (genvar k = 0; k < N_STREAMS; k++) begin : g_port
    assign hit[k]        = en_i && (idx_i == IDX_W'(k));
    assign fe_ready_o[k] = hit[k] && sel_ready_i;
  end

  always_comb begin
    sel_valid_o = 1'b0;
    sel_data_o  = '0;
    sel_last_o  = 1'b0;
    for (int k = 0; k < N_STREAMS; k++) begin
      if (hit[k]) begin
        sel_valid_o = fe_valid_i[k];
        sel_data_o  = fe_data_i[k*DATA_W +: DATA_W];
        sel_last_o  = fe_last_i[k];
      end
    end
  end
endmodule

// File: rtl/efb_word_fmt.sv
module efb_word_fmt
  import efb_pkg::*;
#(
  parameter int          DATA_W        = 32,
  parameter int          EVT_W         = 24,
  parameter int          BCID_W        = 12,
  parameter logic [7:0]  MODULE_ID     = 8'h5C,
  parameter logic [31:0] FIXED_PATTERN = 32'hC0DE_5A5A,
  localparam int         MOD_W         = DATA_W - EVT_W,
  localparam int         PAD_W         = DATA_W - STATUS_W - BCID_W
) (
  input  word_kind_e           kind_i,
  input  pay_mode_e            mode_i,
  input  logic [EVT_W-1:0]     evt_i,
  input  logic [BCID_W-1:0]    bcid_i,
  input  logic [STATUS_W-1:0]  status_i,
  input  logic [DATA_W-1:0]    pay_i,
  input  logic [DATA_W-1:0]    pattern_i,
  output logic [DATA_W-1:0]    word_o
);
  logic [DATA_W-1:0] pay_word;

  always_comb begin
    case (mode_i)
      MODE_LIVE:  pay_word = pay_i;
      MODE_FIXED: pay_word = DATA_W'(FIXED_PATTERN);
      default:    pay_word = pattern_i;
    endcase
  end

  always_comb begin
    case (kind_i)
      WORD_HDR0: word_o = {MOD_W'(MODULE_ID), evt_i};
      WORD_HDR1: word_o = {status_i, {PAD_W{1'b0}}, bcid_i};
      default:   word_o = pay_word;
    endcase
  end
endmodule

// File: rtl/evt_frag_builder.sv
module evt_frag_builder
  import efb_pkg::*;
#(
  parameter int          N_STREAMS     = 3,
  parameter int          DATA_W        = 32,
  parameter int          EVT_W         = 24,
  parameter int          BCID_W        = 12,
  parameter int          SHORT_W       = 4,
  parameter logic [7:0]  MODULE_ID     = 8'h5C,
  parameter logic [31:0] FIXED_PATTERN = 32'hC0DE_5A5A,
  localparam int         IDX_W         = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tag_valid_i,
  output logic                        tag_ready_o,
  input  logic [EVT_W-1:0]            tag_evt_i,
  input  logic [BCID_W-1:0]           tag_bcid_i,
  input  logic [N_STREAMS-1:0]        fe_valid_i,
  output logic [N_STREAMS-1:0]        fe_ready_o,
  input  logic [N_STREAMS*DATA_W-1:0] fe_data_i,
  input  logic [N_STREAMS-1:0]        fe_last_i,
  input  logic                        fe_reset_i,
  input  logic [1:0]                  test_mode_i,
  input  logic [DATA_W-1:0]           test_pattern_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [DATA_W-1:0]           out_data_o,
  output logic                        out_sop_o,
  output logic                        out_eop_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STREAMS - 1);

  fsm_e                 state_q;
  logic [IDX_W-1:0]     sidx_q;
  logic [EVT_W-1:0]     evt_q;
  logic [BCID_W-1:0]    bcid_q;
  pay_mode_e            mode_q;
  logic                 rst_ev_q;
  logic                 mism_q;
  logic                 sticky_q;
  logic [N_STREAMS-1:0] empty_q;

  logic                 mux_en, sel_ready, sel_valid, sel_last;
  logic [DATA_W-1:0]    sel_data;
  logic [N_STREAMS-1:0] match;
  logic                 cur_match;
  logic                 rest_live;
  logic                 hdr_only;
  logic [STATUS_W-1:0]  status;
  word_kind_e           kind;
  pay_mode_e            mode_in;

  efb_id_check #(
    .N_STREAMS(N_STREAMS), .DATA_W(DATA_W), .SHORT_W(SHORT_W), .BCID_W(BCID_W)
  ) u_id_check (
    .beat_data_i (fe_data_i),
    .local_evt_i (evt_q[SHORT_W-1:0]),
    .local_bcid_i(bcid_q),
    .match_o     (match)
  );

  efb_stream_mux #(
    .N_STREAMS(N_STREAMS), .DATA_W(DATA_W)
  ) u_mux (
    .en_i       (mux_en),
    .idx_i      (sidx_q),
    .fe_valid_i (fe_valid_i),
    .fe_data_i  (fe_data_i),
    .fe_last_i  (fe_last_i),
    .fe_ready_o (fe_ready_o),
    .sel_ready_i(sel_ready),
    .sel_valid_o(sel_valid),
    .sel_data_o (sel_data),
    .sel_last_o (sel_last)
  );

  efb_word_fmt #(
    .DATA_W(DATA_W), .EVT_W(EVT_W), .BCID_W(BCID_W),
    .MODULE_ID(MODULE_ID), .FIXED_PATTERN(FIXED_PATTERN)
  ) u_fmt (
    .kind_i   (kind),
    .mode_i   (mode_q),
    .evt_i    (evt_q),
    .bcid_i   (bcid_q),
    .status_i (status),
    .pay_i    (sel_data),
    .pattern_i(test_pattern_i),
    .word_o   (out_data_o)
  );

  always_comb begin
    cur_match = 1'b0;
    for (int k = 0; k < N_STREAMS; k++)
      if (sidx_q == IDX_W'(k)) cur_match = match[k];
  end

  // any non-empty piece left beyond the current stream
  always_comb begin
    rest_live = 1'b0;
    for (int k = 0; k < N_STREAMS; k++)
      if (IDX_W'(k) > sidx_q && !empty_q[k]) rest_live = 1'b1;
  end

  assign hdr_only = &empty_q;

  always_comb begin
    status                = '0;
    status[ST_SYNC]       = !rst_ev_q && (mism_q || sticky_q);
    status[ST_FE_ERR]     = rst_ev_q;
    status[ST_PHYS]       = !rst_ev_q && (mode_q == MODE_LIVE);
    status[ST_TEST]       = !rst_ev_q && (mode_q != MODE_LIVE);
    status[ST_EMPTY]      = hdr_only;
  end

  always_comb begin
    case (test_mode_i)
      2'd0:    mode_in = MODE_LIVE;
      2'd1:    mode_in = MODE_FIXED;
      default: mode_in = MODE_LOADED;
    endcase
  end

  always_comb begin
    mux_en      = 1'b0;
    sel_ready   = 1'b0;
    out_valid_o = 1'b0;
    out_sop_o   = 1'b0;
    out_eop_o   = 1'b0;
    kind        = WORD_PAY;
    tag_ready_o = 1'b0;
    case (state_q)
      S_IDLE: tag_ready_o = 1'b1;
      S_IDS: begin
        mux_en    = 1'b1;
        sel_ready = 1'b1;
      end
      S_HDR0: begin
        out_valid_o = 1'b1;
        out_sop_o   = 1'b1;
        kind        = WORD_HDR0;
      end
      S_HDR1: begin
        out_valid_o = 1'b1;
        out_eop_o   = hdr_only;
        kind        = WORD_HDR1;
      end
      S_PAY: begin
        mux_en      = 1'b1;
        sel_ready   = out_ready_i && !empty_q[sidx_q];
        out_valid_o = sel_valid && !empty_q[sidx_q];
        out_eop_o   = sel_last && !rest_live;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      sidx_q   <= '0;
      evt_q    <= '0;
      bcid_q   <= '0;
      mode_q   <= MODE_LIVE;
      rst_ev_q <= 1'b0;
      mism_q   <= 1'b0;
      empty_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (tag_valid_i) begin
          evt_q    <= tag_evt_i;
          bcid_q   <= tag_bcid_i;
          mode_q   <= mode_in;
          rst_ev_q <= fe_reset_i;
          mism_q   <= 1'b0;
          sidx_q   <= '0;
          empty_q  <= fe_reset_i ? '1 : '0;
          state_q  <= fe_reset_i ? S_HDR0 : S_IDS;
        end
        S_IDS: if (sel_valid) begin
          if (!cur_match) mism_q <= 1'b1;
          empty_q[sidx_q] <= sel_last;
          if (sidx_q == LAST_IDX) begin
            sidx_q  <= '0;
            state_q <= S_HDR0;
          end else begin
            sidx_q <= sidx_q + 1'b1;
          end
        end
        S_HDR0: if (out_ready_i) state_q <= S_HDR1;
        S_HDR1: if (out_ready_i) state_q <= hdr_only ? S_IDLE : S_PAY;
        S_PAY: begin
          if (empty_q[sidx_q]) begin
            sidx_q <= sidx_q + 1'b1;
          end else if (sel_valid && out_ready_i && sel_last) begin
            if (rest_live) sidx_q <= sidx_q + 1'b1;
            else           state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // sync error persists across events until the front end is reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       sticky_q <= 1'b0;
    else if (fe_reset_i)                               sticky_q <= 1'b0;
    else if (state_q == S_IDS && sel_valid && !cur_match) sticky_q <= 1'b1;
  end
endmodule

// File: rtl/efb_checker.sv
module efb_checker
  import efb_pkg::*;
#(
  parameter int N_STREAMS = 3,
  parameter int DATA_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tag_valid_i,
  input logic                 tag_ready_o,
  input logic [N_STREAMS-1:0] fe_ready_o,
  input logic                 fe_reset_i,
  input logic                 out_valid_o,
  input logic                 out_ready_i,
  input logic [DATA_W-1:0]    out_data_o,
  input logic                 out_sop_o,
  input logic                 out_eop_o
);
  logic [1:0] pos_q;
  logic       in_frag_q;
  logic       rst_frag_q;
  logic       out_hs, tag_hs;

  assign out_hs = out_valid_o && out_ready_i;
  assign tag_hs = tag_valid_i && tag_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '0;
      in_frag_q  <= 1'b0;
      rst_frag_q <= 1'b0;
    end else begin
      if (out_hs) pos_q <= out_eop_o ? 2'd0 : ((pos_q == 2'd2) ? 2'd2 : pos_q + 2'd1);
      if (tag_hs) begin
        in_frag_q  <= 1'b1;
        rst_frag_q <= fe_reset_i;
      end else if (out_hs && out_eop_o) begin
        in_frag_q  <= 1'b0;
        rst_frag_q <= 1'b0;
      end
    end
  end

  assert_sop_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_sop_o == (pos_q == 2'd0)));

  assert_hold_stalled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_empty_ends_hdr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pos_q == 2'd1) |-> (out_eop_o == out_data_o[16+ST_EMPTY]));

  assert_tag_between_frags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_hs |-> !in_frag_q);

  assert_reset_no_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_frag_q |-> (fe_ready_o == '0));

  assert_reset_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pos_q == 2'd1 && rst_frag_q) |->
      (out_data_o[16+ST_FE_ERR] && !out_data_o[16+ST_SYNC]));

  assert_marker_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_sop_o && out_eop_o));

  assert_one_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fe_ready_o));
endmodule

bind evt_frag_builder efb_checker #(
  .N_STREAMS(N_STREAMS), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tag_valid_i(tag_valid_i),
  .tag_ready_o(tag_ready_o),
  .fe_ready_o (fe_ready_o),
  .fe_reset_i (fe_reset_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .out_sop_o  (out_sop_o),
  .out_eop_o  (out_eop_o)
);

// File: tb/tb_evt_frag_builder.sv
module tb_evt_frag_builder;
  localparam int NS = 3;
  localparam int DW = 32;
  localparam logic [31:0] FIXED = 32'hC0DE_5A5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           tag_valid = 1'b0;
  logic           tag_ready;
  logic [23:0]    tag_evt = '0;
  logic [11:0]    tag_bcid = '0;
  logic [NS-1:0]  fe_valid = '0;
  logic [NS-1:0]  fe_ready;
  logic [NS*DW-1:0] fe_data = '0;
  logic [NS-1:0]  fe_last = '0;
  logic           fe_reset = 1'b0;
  logic [1:0]     test_mode = 2'd0;
  logic [DW-1:0]  test_pattern = 32'h1234_ABCD;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [DW-1:0]  out_data;
  logic           out_sop, out_eop;

  evt_frag_builder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tag_valid_i(tag_valid), .tag_ready_o(tag_ready),
    .tag_evt_i(tag_evt), .tag_bcid_i(tag_bcid),
    .fe_valid_i(fe_valid), .fe_ready_o(fe_ready),
    .fe_data_i(fe_data), .fe_last_i(fe_last),
    .fe_reset_i(fe_reset), .test_mode_i(test_mode), .test_pattern_i(test_pattern),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sop_o(out_sop), .out_eop_o(out_eop)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [32:0] sq [NS][$];   // {last, data}
  logic [35:0] tq [$];       // {evt, bcid}
  logic [33:0] eq [$];       // {sop, eop, data}
  string       er [$];

  bit          sticky = 1'b0;
  bit          stall = 1'b0;
  int          cyc = 0;
  bit [NS-1:0] hs_fe = '0;
  bit          hs_tag = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_exp(input bit sop, input bit eop, input logic [31:0] d, input string req);
    eq.push_back({sop, eop, d});
    er.push_back(req);
  endtask

  // bad_kind: 0 none, 1 short event number, 2 crossing number
  task automatic send_event(input logic [23:0] evt, input logic [11:0] bcid,
                            input int len0, input int len1, input int len2,
                            input int bad_s, input int bad_kind, input string req);
    int lens [NS];
    bit mism;
    bit all_empty;
    logic [15:0] st;
    lens[0] = len0; lens[1] = len1; lens[2] = len2;
    mism = (bad_kind != 0);
    all_empty = (len0 == 0) && (len1 == 0) && (len2 == 0);
    if (mism) sticky = 1'b1;
    st = '0;
    st[0] = sticky;
    st[2] = (test_mode == 2'd0);
    st[3] = (test_mode != 2'd0);
    st[4] = all_empty;
    tq.push_back({evt, bcid});
    push_exp(1'b1, 1'b0, {8'h5C, evt}, req);
    push_exp(1'b0, all_empty, {st, 4'h0, bcid}, req);
    for (int s = 0; s < NS; s++) begin
      logic [3:0]  se;
      logic [11:0] sb;
      se = evt[3:0];
      sb = bcid;
      if (s == bad_s && bad_kind == 1) se = se ^ 4'h1;
      if (s == bad_s && bad_kind == 2) sb = sb ^ 12'h001;
      sq[s].push_back({lens[s] == 0, 16'h0, se, sb});
      for (int i = 0; i < lens[s]; i++) begin
        logic [31:0] d;
        bit lastw;
        d = {evt[7:0], 8'(s), 16'(i)};
        sq[s].push_back({i == lens[s] - 1, d});
        lastw = (i == lens[s] - 1);
        for (int t = s + 1; t < NS; t++) if (lens[t] != 0) lastw = 1'b0;
        push_exp(1'b0, lastw,
                 (test_mode == 2'd0) ? d : ((test_mode == 2'd1) ? FIXED : test_pattern), req);
      end
    end
  endtask

  task automatic send_reset_event(input logic [23:0] evt, input logic [11:0] bcid);
    sticky = 1'b0;
    tq.push_back({evt, bcid});
    push_exp(1'b1, 1'b0, {8'h5C, evt}, "R9");
    push_exp(1'b0, 1'b1, {16'h0012, 4'h0, bcid}, "R9");
  endtask

  task automatic drain();
    while (eq.size() != 0 || tq.size() != 0 ||
           sq[0].size() != 0 || sq[1].size() != 0 || sq[2].size() != 0)
      @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // driver and monitor: inputs change at negedge, handshakes sampled before next posedge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      for (int s = 0; s < NS; s++) if (hs_fe[s]) void'(sq[s].pop_front());
      if (hs_tag) void'(tq.pop_front());
      for (int s = 0; s < NS; s++) begin
        if (sq[s].size() != 0) begin
          fe_valid[s] = 1'b1;
          fe_last[s]  = sq[s][0][32];
          fe_data[s*DW +: DW] = sq[s][0][31:0];
        end else begin
          fe_valid[s] = 1'b0;
          fe_last[s]  = 1'b0;
          fe_data[s*DW +: DW] = '0;
        end
      end
      tag_valid = (tq.size() != 0);
      if (tq.size() != 0) {tag_evt, tag_bcid} = tq[0];
      out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      for (int s = 0; s < NS; s++) hs_fe[s] = fe_valid[s] && fe_ready[s];
      hs_tag = tag_valid && tag_ready;
      if (fe_reset) check(fe_ready == '0, "R9", 64'(fe_ready), 64'h0);
      if ((fe_ready & (fe_ready - 1'b1)) != '0)
        check(1'b0, "R10", 64'(fe_ready), 64'h0);
      if (out_valid && out_ready) begin
        if (eq.size() == 0) begin
          check(1'b0, "R6", 64'({out_sop, out_eop, out_data}), 64'h0);
        end else begin
          logic [33:0] e;
          string r;
          e = eq.pop_front();
          r = er.pop_front();
          check({out_sop, out_eop, out_data} == e, r, 64'({out_sop, out_eop, out_data}), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired, pending words=%0d", eq.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'h0);
    check(fe_ready == '0, "R10", 64'(fe_ready), 64'h0);
    check(tag_ready == 1'b1, "R6", 64'(tag_ready), 64'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3: aligned live events, several piece shapes
    send_event(24'h00_0101, 12'h0A1, 2, 1, 3, -1, 0, "R3");
    send_event(24'h00_0102, 12'h0A2, 0, 2, 0, -1, 0, "R2");
    send_event(24'h00_0103, 12'h0A3, 1, 0, 1, -1, 0, "R2");
    drain();
    // R5: all pieces empty
    send_event(24'h00_0104, 12'h0A4, 0, 0, 0, -1, 0, "R5");
    drain();
    // R6: back-to-back tags with output stalls
    stall = 1'b1;
    for (int k = 0; k < 4; k++)
      send_event(24'h12_3400 + 24'(k), 12'h100 + 12'(k), k, 1, 3 - k, -1, 0, "R6");
    drain();
    stall = 1'b0;
    // R4: mismatch keeps flowing and stays flagged
    send_event(24'h00_0200, 12'h200, 1, 1, 1, 1, 1, "R4");
    send_event(24'h00_0201, 12'h201, 2, 0, 1, -1, 0, "R4");
    send_event(24'h00_0202, 12'h202, 0, 0, 0, 2, 2, "R4");
    send_event(24'h00_0203, 12'h203, 1, 1, 0, -1, 0, "R4");
    drain();
    // R9: local front-end reset, streams untouched
    fe_reset = 1'b1;
    send_reset_event(24'h00_0300, 12'h300);
    send_reset_event(24'h00_0301, 12'h301);
    drain();
    fe_reset = 1'b0;
    repeat (2) @(posedge clk);
    // R4: flag cleared after reset
    send_event(24'h00_0302, 12'h302, 1, 2, 1, -1, 0, "R4");
    drain();
    // R7: fixed pattern
    test_mode = 2'd1;
    send_event(24'h00_0400, 12'h400, 2, 1, 0, -1, 0, "R7");
    send_event(24'h00_0401, 12'h401, 0, 0, 0, -1, 0, "R7");
    drain();
    // R8: loaded pattern
    test_mode = 2'd2;
    test_pattern = 32'hFACE_0BAD;
    stall = 1'b1;
    send_event(24'h00_0500, 12'h500, 1, 3, 2, -1, 0, "R8");
    drain();
    stall = 1'b0;
    test_mode = 2'd0;

    check(eq.size() == 0, "R6", 64'(eq.size()), 64'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule